// File: doc/BRIEF.md
# Banked Interrupt Controller Register Interface

This block is the software-visible register file of a 96-line interrupt controller. The lines are split into banks of 32. It takes word accesses over a simple valid/write/address/data bus. It holds the per-line configuration and the per-bank masks, and it turns register writes into one-cycle strobes for the neighbouring logic:

- the capture banks receive software request set and clear strobes and a soft-reset strobe;
- the arbiter receives a re-evaluation strobe and the two acknowledge ("new agreement") strobes.

Line capture and arbitration sit outside the block. It reads the raw line levels and the captured pending bits from the capture banks. It reads the two latched vector numbers from the arbiter and returns them to software. A read returns its data in the cycle after the request. An access to an address that maps to nothing raises a one-cycle error flag.

Per-bank registers sit in a window that starts at 0x80. Address bits [6:5] select the bank. Per-line words start at 0x100, with one word per line and 0x80 bytes per bank. The bank count and the priority width are parameters.

Top module: `intc_reg_if`

## Requirements
- R1: After reset, every mask bit is 1, every fast-routing bit and priority is 0, the global mask, autoidle and idle bits are 0, address 0x00 reads 0x21 and address 0x14 reads 1.
- R2: A read returns its data on `bus_rdata` in the cycle after `bus_valid` is sampled, and `bus_rdata` then holds that value. The error flag for an access is high only in the cycle after that access.
- R3: In bank b, the mask register is at 0x80+0x20·b+0x04. A write there replaces the mask. Writing 1s at +0x08 clears those mask bits, and writing 1s at +0x0C sets them. A replace or clear write pulses `reeval_o` in the next cycle; a set write does not.
- R4: Bank offset +0x00 reads the raw line levels of the bank. +0x18 reads pending AND NOT mask AND NOT fast. +0x1C reads pending AND NOT mask AND fast. Writes to these offsets have no effect and raise no error.
- R5: A write to bank offset +0x10 pulses the written bits on that bank's lanes of `swi_set_o` for one cycle. A write to +0x14 does the same on `swi_clr_o`. Both offsets read 0.
- R6: The word at 0x100+0x80·b+4·l configures line 32·b+l. Bits [7:2] hold its priority and bit 0 its fast-routing select. The word reads back in the same layout and drives `prio_o` and `fast_sel_o`.
- R7: At 0x48, bit 2 is the stored global mask and reads back at bit 2. Writing bit 1 pulses `ack_fast_o` in the next cycle, and writing bit 0 pulses `ack_norm_o`.
- R8: At 0x10, bit 0 is autoidle and reads back. Writing bit 1 returns all state to its reset values and pulses `soft_rst_o` in the next cycle.
- R9: 0x40 reads `vec_norm_i` and 0x44 reads `vec_fast_i`. 0x4C reads 0. 0x50 keeps bits [1:0] of a write.
- R10: Each of these accesses raises `bus_err` and reads 0: a bank index of 3 or more (0xE0–0xFF), a line word at 0x280 or above, any other unmapped address, and a misaligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Error pulse for an unmapped access |
| line_raw | input | 96 | Raw line levels from the capture banks |
| line_pend | input | 96 | Pending bits from the capture banks |
| vec_norm_i | input | 7 | Latched normal vector number |
| vec_fast_i | input | 7 | Latched fast vector number |
| mask_o | output | 96 | Per-line mask |
| fast_sel_o | output | 96 | Per-line fast-routing select |
| prio_o | output | 576 | Per-line priority, 6 bits per line |
| glob_mask_o | output | 1 | Global mask (disables both outputs) |
| autoidle_o | output | 1 | Autoidle enable |
| idle_o | output | 2 | Idle control bits |
| swi_set_o | output | 96 | Software request set strobe |
| swi_clr_o | output | 96 | Software request clear strobe |
| reeval_o | output | 1 | Arbiter re-evaluation strobe |
| ack_norm_o | output | 1 | New normal agreement strobe |
| ack_fast_o | output | 1 | New fast agreement strobe |
| soft_rst_o | output | 1 | Soft reset strobe |

## Verification
The assertions watch several behaviours on every cycle:

- a mask-clear write leaves the written bits clear;
- a mask-set write never clears a bit;
- a line-word write lands its routing bit on the addressed line;
- the re-evaluation and error pulses only follow an access;
- a status read returns 1;
- the soft-reset strobe always coincides with fully masked lines.

Only the directed scenarios can show the rest:

- the read-back values and the pending formulas against chosen pending patterns;
- the absence of a re-evaluation pulse after a mask-set write;
- the error decoding of out-of-range banks, line words and misaligned addresses;
- the full clearing of configuration by the soft reset.

// File: rtl/intc_regs_pkg.sv
package intc_regs_pkg;

   // Offset of a register inside one bank window (address bits [4:2])
   typedef enum logic [2:0] {
      BK_RAW   = 3'd0,
      BK_MASK  = 3'd1,
      BK_MCLR  = 3'd2,
      BK_MSET  = 3'd3,
      BK_SSET  = 3'd4,
      BK_SCLR  = 3'd5,
      BK_PNORM = 3'd6,
      BK_PFAST = 3'd7
   } bank_reg_e;

   localparam logic [11:0] A_REV     = 12'h000;
   localparam logic [11:0] A_SYSCFG  = 12'h010;
   localparam logic [11:0] A_SYSSTAT = 12'h014;
   localparam logic [11:0] A_VNORM   = 12'h040;
   localparam logic [11:0] A_VFAST   = 12'h044;
   localparam logic [11:0] A_CTRL    = 12'h048;
   localparam logic [11:0] A_PROT    = 12'h04C;
   localparam logic [11:0] A_IDLE    = 12'h050;
   localparam logic [11:0] LINE_BASE = 12'h100;

endpackage

// File: rtl/intc_bank_regs.sv
module intc_bank_regs #(
   parameter int LANE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_clear,
   input  logic              wr_mask,
   input  logic              wr_mclr,
   input  logic              wr_mset,
   input  logic              wr_sset,
   input  logic              wr_sclr,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] mask,
   output logic [LANE_W-1:0] swi_set,
   output logic [LANE_W-1:0] swi_clr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask    <= '1;
         swi_set <= '0;
         swi_clr <= '0;
      end else if (sw_clear) begin
         mask    <= '1;
         swi_set <= '0;
         swi_clr <= '0;
      end else begin
         if (wr_mask)      mask <= wdata;
         else if (wr_mclr) mask <= mask & ~wdata;
         else if (wr_mset) mask <= mask | wdata;
         swi_set <= wr_sset ? wdata : '0;
         swi_clr <= wr_sclr ? wdata : '0;
      end
   end

   // R3: a clear write leaves every written bit unmasked
   assert_mclr_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mclr && !sw_clear) |=> ((mask & $past(wdata)) == '0));

   // R3: a set write never unmasks a line
   assert_mset_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mset && !sw_clear) |=> ((mask & $past(mask)) == $past(mask)));

endmodule

// File: rtl/intc_line_cfg.sv
module intc_line_cfg #(
   parameter int LANES  = 32,
   parameter int PRIO_W = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sw_clear,
   input  logic                      wr_en,
   input  logic [$clog2(LANES)-1:0]  line_sel,
   input  logic [PRIO_W-1:0]         wr_prio,
   input  logic                      wr_fast,
   output logic [LANES*PRIO_W-1:0]   prio,
   output logic [LANES-1:0]          fast
);

   localparam int SEL_W = $clog2(LANES);

   for (genvar l = 0; l < LANES; l++) begin : g_line
      logic [PRIO_W-1:0] prio_q;
      logic              fast_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q <= '0;
            fast_q <= 1'b0;
         end else if (sw_clear) begin
            prio_q <= '0;
            fast_q <= 1'b0;
         end else if (wr_en && line_sel == SEL_W'(l)) begin
            prio_q <= wr_prio;
            fast_q <= wr_fast;
         end
      end

      assign prio[l*PRIO_W +: PRIO_W] = prio_q;
      assign fast[l]                  = fast_q;
   end

   // R6: the routing bit written lands on the addressed line
   assert_line_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sw_clear) |=> (fast[$past(line_sel)] == $past(wr_fast)));

endmodule

// File: rtl/intc_reg_if.sv
module intc_reg_if
   import intc_regs_pkg::*;
#(
   parameter int          NUM_BANKS = 3,
   parameter int          PRIO_W    = 6,
   parameter logic [7:0]  REVISION  = 8'h21
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        bus_valid,
   input  logic                                        bus_write,
   input  logic [11:0]                                 bus_addr,
   input  logic [31:0]                                 bus_wdata,
   output logic [31:0]                                 bus_rdata,
   output logic                                        bus_err,
   input  logic [NUM_BANKS*32-1:0]                     line_raw,
   input  logic [NUM_BANKS*32-1:0]                     line_pend,
   input  logic [$clog2(NUM_BANKS*32)-1:0]             vec_norm_i,
   input  logic [$clog2(NUM_BANKS*32)-1:0]             vec_fast_i,
   output logic [NUM_BANKS*32-1:0]                     mask_o,
   output logic [NUM_BANKS*32-1:0]                     fast_sel_o,
   output logic [NUM_BANKS*32*PRIO_W-1:0]              prio_o,
   output logic                                        glob_mask_o,
   output logic                                        autoidle_o,
   output logic [1:0]                                  idle_o,
   output logic [NUM_BANKS*32-1:0]                     swi_set_o,
   output logic [NUM_BANKS*32-1:0]                     swi_clr_o,
   output logic                                        reeval_o,
   output logic                                        ack_norm_o,
   output logic                                        ack_fast_o,
   output logic                                        soft_rst_o
);

   localparam int LANE_W    = 32;
   localparam int NUM_LINES = NUM_BANKS * LANE_W;
   localparam int LIDX_W    = $clog2(NUM_LINES);
   localparam int LBANK_W   = LIDX_W - 5;
   localparam int LINE_SPAN = NUM_BANKS * 128;

   if (NUM_BANKS < 2 || NUM_BANKS > 4) begin : g_bad_banks
      $error("NUM_BANKS must lie in 2..4");
   end
   if (PRIO_W < 1 || PRIO_W > 6) begin : g_bad_prio
      $error("PRIO_W must lie in 1..6");
   end

   // ---------------- decode ----------------
   logic              aligned, is_bank, bank_ok, is_line, hit, sw_clear;
   logic              acc_wr, acc_rd;
   logic [1:0]        bank_idx;
   bank_reg_e         bank_off;
   logic [LIDX_W-1:0] line_idx;
   logic [31:0]       rd_val;

   assign acc_wr   = bus_valid & bus_write;
   assign acc_rd   = bus_valid & ~bus_write;
   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign is_bank  = (bus_addr[11:7] == 5'b00001);
   assign bank_idx = bus_addr[6:5];
   assign bank_ok  = (int'(bank_idx) < NUM_BANKS);
   assign bank_off = bank_reg_e'(bus_addr[4:2]);
   assign is_line  = (int'(bus_addr) >= int'(LINE_BASE)) &&
                     (int'(bus_addr) <  int'(LINE_BASE) + LINE_SPAN);
   assign line_idx = LIDX_W'((bus_addr - LINE_BASE) >> 2);
   assign sw_clear = acc_wr & aligned & (bus_addr == A_SYSCFG) & bus_wdata[1];

   // ---------------- per-bank state ----------------
   logic [NUM_BANKS-1:0] wr_mask_v, wr_mclr_v;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_wr, line_wr;
      assign bank_wr = acc_wr & aligned & is_bank & (bank_idx == 2'(b));
      assign line_wr = acc_wr & aligned & is_line &
                       (line_idx[LIDX_W-1:5] == LBANK_W'(b));
      assign wr_mask_v[b] = bank_wr & (bank_off == BK_MASK);
      assign wr_mclr_v[b] = bank_wr & (bank_off == BK_MCLR);

      intc_bank_regs #(.LANE_W(LANE_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .sw_clear (sw_clear),
         .wr_mask  (wr_mask_v[b]),
         .wr_mclr  (wr_mclr_v[b]),
         .wr_mset  (bank_wr & (bank_off == BK_MSET)),
         .wr_sset  (bank_wr & (bank_off == BK_SSET)),
         .wr_sclr  (bank_wr & (bank_off == BK_SCLR)),
         .wdata    (bus_wdata),
         .mask     (mask_o[b*LANE_W +: LANE_W]),
         .swi_set  (swi_set_o[b*LANE_W +: LANE_W]),
         .swi_clr  (swi_clr_o[b*LANE_W +: LANE_W])
      );

      intc_line_cfg #(.LANES(LANE_W), .PRIO_W(PRIO_W)) u_lines (
         .clk      (clk),
         .rst_n    (rst_n),
         .sw_clear (sw_clear),
         .wr_en    (line_wr),
         .line_sel (line_idx[4:0]),
         .wr_prio  (bus_wdata[2 +: PRIO_W]),
         .wr_fast  (bus_wdata[0]),
         .prio     (prio_o[b*LANE_W*PRIO_W +: LANE_W*PRIO_W]),
         .fast     (fast_sel_o[b*LANE_W +: LANE_W])
      );
   end

   // ---------------- read mux ----------------
   logic       glob_q, autoidle_q;
   logic [1:0] idle_q;

   always_comb begin
      hit    = 1'b0;
      rd_val = '0;
      if (aligned) begin
         if (is_bank) begin
            hit = bank_ok;
            for (int b = 0; b < NUM_BANKS; b++) begin
               if (bank_idx == 2'(b)) begin
                  case (bank_off)
                     BK_RAW:   rd_val = line_raw[b*LANE_W +: LANE_W];
                     BK_MASK:  rd_val = mask_o[b*LANE_W +: LANE_W];
                     BK_PNORM: rd_val = line_pend[b*LANE_W +: LANE_W] &
                                        ~mask_o[b*LANE_W +: LANE_W] &
                                        ~fast_sel_o[b*LANE_W +: LANE_W];
                     BK_PFAST: rd_val = line_pend[b*LANE_W +: LANE_W] &
                                        ~mask_o[b*LANE_W +: LANE_W] &
                                        fast_sel_o[b*LANE_W +: LANE_W];
                     default:  rd_val = '0;
                  endcase
               end
            end
         end else if (is_line) begin
            hit = 1'b1;
            for (int i = 0; i < NUM_LINES; i++) begin
               if (line_idx == LIDX_W'(i)) begin
                  rd_val[2 +: PRIO_W] = prio_o[i*PRIO_W +: PRIO_W];
                  rd_val[0]           = fast_sel_o[i];
               end
            end
         end else begin
            hit = 1'b1;
            case (bus_addr)
               A_REV:     rd_val[7:0]        = REVISION;
               A_SYSCFG:  rd_val[0]          = autoidle_q;
               A_SYSSTAT: rd_val[0]          = 1'b1;
               A_VNORM:   rd_val[LIDX_W-1:0] = vec_norm_i;
               A_VFAST:   rd_val[LIDX_W-1:0] = vec_fast_i;
               A_CTRL:    rd_val[2]          = glob_q;
               A_PROT:    rd_val             = '0;
               A_IDLE:    rd_val[1:0]        = idle_q;
               default:   hit                = 1'b0;
            endcase
         end
      end
   end

   // ---------------- global state and strobes ----------------
   logic wr_ctrl, wr_syscfg, wr_idle;
   assign wr_ctrl   = acc_wr & (bus_addr == A_CTRL);
   assign wr_syscfg = acc_wr & (bus_addr == A_SYSCFG);
   assign wr_idle   = acc_wr & (bus_addr == A_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_q     <= 1'b0;
         autoidle_q <= 1'b0;
         idle_q     <= 2'b00;
         ack_norm_o <= 1'b0;
         ack_fast_o <= 1'b0;
         reeval_o   <= 1'b0;
         soft_rst_o <= 1'b0;
         bus_rdata  <= '0;
         bus_err    <= 1'b0;
      end else begin
         soft_rst_o <= sw_clear;
         bus_err    <= bus_valid & ~hit;
         if (acc_rd) bus_rdata <= hit ? rd_val : '0;
         if (sw_clear) begin
            glob_q     <= 1'b0;
            autoidle_q <= 1'b0;
            idle_q     <= 2'b00;
            ack_norm_o <= 1'b0;
            ack_fast_o <= 1'b0;
            reeval_o   <= 1'b0;
         end else begin
            ack_norm_o <= wr_ctrl & bus_wdata[0];
            ack_fast_o <= wr_ctrl & bus_wdata[1];
            reeval_o   <= |(wr_mask_v | wr_mclr_v);
            if (wr_ctrl)   glob_q     <= bus_wdata[2];
            if (wr_syscfg) autoidle_q <= bus_wdata[0];
            if (wr_idle)   idle_q     <= bus_wdata[1:0];
         end
      end
   end

   assign glob_mask_o = glob_q;
   assign autoidle_o  = autoidle_q;
   assign idle_o      = idle_q;

   // R2 / R10: an error pulse only ever follows an access
   assert_err_after_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_valid));

   // R1: the status word always reads 1
   assert_status_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == A_SYSSTAT) |=> (bus_rdata == 32'd1 && !bus_err));

   // R3: re-evaluation only follows a write
   assert_reeval_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reeval_o |-> $past(bus_valid && bus_write));

   // R8: the soft-reset strobe coincides with fully masked lines
   assert_soft_reset_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> ((&mask_o) && !glob_mask_o));

endmodule

// File: tb/intc_reg_if_tb.sv
`timescale 1ns/1ps
module intc_reg_if_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_valid = 1'b0, bus_write = 1'b0;
   logic [11:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         bus_err;
   logic [95:0]  line_raw  = {32'hA5A5_0F0F, 32'h0BAD_F00D, 32'h1357_9BDF};
   logic [95:0]  line_pend = {32'hDEAD_BEEF, 32'h1234_F00F, 32'hCAFE_0001};
   logic [6:0]   vec_norm_i = 7'd45, vec_fast_i = 7'd90;
   logic [95:0]  mask_o, fast_sel_o, swi_set_o, swi_clr_o;
   logic [575:0] prio_o;
   logic         glob_mask_o, autoidle_o, reeval_o, ack_norm_o, ack_fast_o, soft_rst_o;
   logic [1:0]   idle_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   intc_reg_if dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .line_raw(line_raw), .line_pend(line_pend),
      .vec_norm_i(vec_norm_i), .vec_fast_i(vec_fast_i), .mask_o(mask_o),
      .fast_sel_o(fast_sel_o), .prio_o(prio_o), .glob_mask_o(glob_mask_o),
      .autoidle_o(autoidle_o), .idle_o(idle_o), .swi_set_o(swi_set_o),
      .swi_clr_o(swi_clr_o), .reeval_o(reeval_o), .ack_norm_o(ack_norm_o),
      .ack_fast_o(ack_fast_o), .soft_rst_o(soft_rst_o)
   );

   task automatic chk(input string req, input string what, input logic [95:0] act, input logic [95:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata; e = bus_err;
   endtask

   task automatic test_reset;
      logic [31:0] d; logic e;
      chk("R1", "mask_o", mask_o, {96{1'b1}});
      chk("R1", "fast_sel_o", fast_sel_o, '0);
      chk("R1", "prio line 40", prio_o[40*6 +: 6], '0);
      chk("R1", "glob/autoidle/idle", {glob_mask_o, autoidle_o, idle_o}, '0);
      bus_rd(12'h000, d, e); chk("R1", "revision", d, 32'h21);
      bus_rd(12'h014, d, e); chk("R1", "status", d, 32'h1);
      bus_rd(12'h0C4, d, e); chk("R1", "bank2 mask read", d, 32'hFFFF_FFFF);
   endtask

   task automatic test_mask;
      logic [31:0] d; logic e;
      bus_wr(12'h0A4, 32'h0000_FF00);
      chk("R3", "reeval after replace", reeval_o, 1'b1);
      chk("R3", "bank1 mask after replace", mask_o[63:32], 32'h0000_FF00);
      chk("R3", "bank0 untouched", mask_o[31:0], 32'hFFFF_FFFF);
      bus_wr(12'h0A8, 32'h0000_0F00);
      chk("R3", "reeval after clear", reeval_o, 1'b1);
      chk("R3", "bank1 mask after clear", mask_o[63:32], 32'h0000_F000);
      bus_wr(12'h0AC, 32'h0000_0003);
      chk("R3", "no reeval after set", reeval_o, 1'b0);
      chk("R3", "bank1 mask after set", mask_o[63:32], 32'h0000_F003);
      bus_rd(12'h0A4, d, e); chk("R3", "mask readback", d, 32'h0000_F003);
      bus_rd(12'h0A8, d, e); chk("R3", "clear alias reads 0", d, 32'h0);
   endtask

   task automatic test_lines;
      logic [31:0] d; logic e;
      bus_wr(12'h188, 32'h0000_0015);
      chk("R6", "prio line 34", prio_o[34*6 +: 6], 6'd5);
      chk("R6", "fast line 34", fast_sel_o[34], 1'b1);
      bus_rd(12'h188, d, e); chk("R6", "line 34 readback", d, 32'h15);
      bus_wr(12'h27C, 32'h0000_00FC);
      chk("R6", "prio line 95", prio_o[95*6 +: 6], 6'd63);
      chk("R6", "fast line 95", fast_sel_o[95], 1'b0);
      bus_rd(12'h27C, d, e); chk("R6", "line 95 readback", {e, d}, {1'b0, 32'hFC});
   endtask

   task automatic test_pending;
      logic [31:0] d; logic e;
      logic [31:0] m, f, p;
      m = 32'h0000_F003; f = 32'h0000_0004; p = line_pend[63:32];
      bus_rd(12'h0B8, d, e); chk("R4", "pending normal", d, p & ~m & ~f);
      bus_rd(12'h0BC, d, e); chk("R4", "pending fast", d, p & ~m & f);
      line_pend[63:32] = 32'h0000_0FFF;
      bus_rd(12'h0B8, d, e); chk("R4", "pending normal new pattern", d, 32'h0000_0FF8);
      bus_rd(12'h0A0, d, e); chk("R4", "raw bank1", d, line_raw[63:32]);
      bus_wr(12'h0A0, 32'h0);
      bus_rd(12'h0A0, d, e); chk("R4", "raw write ignored", {e, d}, {1'b0, line_raw[63:32]});
      bus_wr(12'h000, 32'h0);
      bus_rd(12'h000, d, e); chk("R4", "revision write ignored", d, 32'h21);
   endtask

   task automatic test_swi;
      logic [31:0] d; logic e;
      bus_wr(12'h0D0, 32'h8000_0001);
      chk("R5", "swi set strobe", swi_set_o, {32'h8000_0001, 64'h0});
      chk("R5", "swi clr quiet", swi_clr_o, '0);
      @(negedge clk);
      chk("R5", "swi set one cycle", swi_set_o, '0);
      bus_wr(12'h094, 32'h0000_0100);
      chk("R5", "swi clr strobe", swi_clr_o, {64'h0, 32'h0000_0100});
      bus_rd(12'h0D0, d, e); chk("R5", "swi set reads 0", d, 32'h0);
   endtask

   task automatic test_control;
      logic [31:0] d; logic e;
      bus_wr(12'h048, 32'h7);
      chk("R7", "acks and glob", {ack_fast_o, ack_norm_o, glob_mask_o}, 3'b111);
      bus_rd(12'h048, d, e); chk("R7", "ctrl readback", d, 32'h4);
      chk("R7", "acks one cycle", {ack_fast_o, ack_norm_o}, 2'b00);
      bus_wr(12'h048, 32'h1);
      chk("R7", "norm only, glob off", {ack_fast_o, ack_norm_o, glob_mask_o}, 3'b010);
   endtask

   task automatic test_misc;
      logic [31:0] d; logic e;
      bus_rd(12'h040, d, e); chk("R9", "normal vector", d, 32'd45);
      bus_rd(12'h044, d, e); chk("R9", "fast vector", d, 32'd90);
      bus_wr(12'h04C, 32'h1);
      bus_rd(12'h04C, d, e); chk("R9", "protection reads 0", {e, d}, {1'b0, 32'h0});
      bus_wr(12'h050, 32'hFF);
      bus_rd(12'h050, d, e); chk("R9", "idle two bits", d, 32'h3);
      chk("R9", "idle_o", idle_o, 2'b11);
   endtask

   task automatic test_errors;
      logic [31:0] d; logic e;
      bus_rd(12'h0E4, d, e); chk("R10", "bank 3 error", {e, d}, {1'b1, 32'h0});
      @(negedge clk); chk("R2", "error lasts one cycle", bus_err, 1'b0);
      chk("R2", "rdata held", bus_rdata, 32'h0);
      bus_rd(12'h280, d, e); chk("R10", "line beyond range", {e, d}, {1'b1, 32'h0});
      bus_rd(12'h020, d, e); chk("R10", "unmapped global", {e, d}, {1'b1, 32'h0});
      bus_rd(12'h18A, d, e); chk("R10", "misaligned", {e, d}, {1'b1, 32'h0});
      bus_wr(12'h0E4, 32'h0);
      chk("R10", "bad write error", bus_err, 1'b1);
      chk("R10", "bad write no mask change", mask_o[63:32], 32'h0000_F003);
   endtask

   task automatic test_sysconfig;
      logic [31:0] d; logic e;
      bus_wr(12'h010, 32'h1);
      chk("R8", "autoidle_o", autoidle_o, 1'b1);
      bus_rd(12'h010, d, e); chk("R8", "autoidle readback", d, 32'h1);
      bus_wr(12'h010, 32'h2);
      chk("R8", "soft reset strobe", soft_rst_o, 1'b1);
      chk("R8", "masks restored", mask_o, {96{1'b1}});
      chk("R8", "routing cleared", fast_sel_o, '0);
      chk("R8", "prio cleared", prio_o[95*6 +: 6], 6'd0);
      chk("R8", "autoidle/idle cleared", {autoidle_o, idle_o}, 3'b000);
      bus_rd(12'h188, d, e); chk("R8", "line word cleared", d, 32'h0);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset;
      test_mask;
      test_lines;
      test_pending;
      test_swi;
      test_control;
      test_misc;
      test_errors;
      test_sysconfig;
      done = 1'b1;
      summary;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary;
      end
   end

endmodule